// File: doc/BRIEF.md
# Bit-Serial Montgomery Modular Multiplier

The block computes the Montgomery product `A * B * 2^-K mod N` of two K-bit operands under an odd K-bit modulus, with both operands smaller than the modulus. It works through the multiplier operand A one bit per clock cycle, least significant bit first, in a radix-2 add-shift loop. Each cycle it adds `B` when the current bit of A is set. It adds `N` when the sum would otherwise be odd, and then halves the total. Whether `N` is added is decided from a predicted parity, the current low accumulator bit XOR (current A bit AND low bit of B), so no full-width comparison sits in the loop. After K steps a single conditional subtraction brings the value into `[0, N-1]`.

A request enters through a valid/ready handshake. The caller holds `in_valid` together with `op_a`, `op_b` and `modulus` until a clock edge where `in_ready` is also high. The block takes the operands at that edge. While a product is in progress, `in_ready` stays low, so any request waits and its operands are not sampled. The result has no back-pressure. `done` pulses for one cycle, and `result` then holds its value until the next product is finished.

Top module: `mont_mul_top`

## Requirements
- R1: After reset, `done` and `busy` are 0, `in_ready` is 1 and `result` is 0.
- R2: For odd `modulus` N and `op_a`, `op_b` < N, the `result` presented with `done` satisfies `(result * 2^K) mod N == (op_a * op_b) mod N`.
- R3: Before every halving step, the accumulator plus the chosen addends is even. That is, the parity predicted from the low accumulator bit, the current A bit and the low bit of B matches the real sum.
- R4: `done` rises exactly K+1 clock cycles after the accepting edge and stays high for one cycle only.
- R5: The presented `result` always lies in `0 .. N-1`, which includes the case where the accumulator equals N before correction.
- R6: `in_ready` equals the inverse of `busy`. A request held on `in_valid` while `busy` is high is not taken and does not alter the product in progress.
- R7: `result` keeps its value from one `done` pulse until the next one.
- R8: Between correction steps the accumulator stays below 2N, so it fits in K+1 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present on the operand inputs |
| in_ready | output | 1 | High when a request can be taken |
| op_a | input | K | Multiplier operand A, consumed LSB first |
| op_b | input | K | Multiplicand operand B |
| modulus | input | K | Odd modulus N |
| busy | output | 1 | A product is being computed |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | K | Montgomery product, held until the next done |

## Verification
On every cycle, the assertions check that the predicted parity matches the true low bit of the sum before each shift. They also check that the accumulator stays below twice the modulus, that a result is always below the modulus, that `done` is a single-cycle pulse, that `result` is held between pulses, and that `in_ready` mirrors `busy`. The arithmetic property, that the result times `2^K` is congruent to `A*B`, can only be shown by the bench's scenarios. The same holds for the exact K+1-cycle latency and for the rejection of a request presented while busy. The bench sweeps every odd modulus of an 8-bit configuration, with extreme and pseudo-random operands for each.

// File: rtl/mont_pkg.sv
package mont_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } mont_state_e;
endpackage

// File: rtl/mont_ctrl.sv
module mont_ctrl #(
  parameter int K = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic accept,
  output logic step_en,
  output logic fix_en,
  output logic busy
);
  import mont_pkg::*;
  localparam int CW = $clog2(K + 1);
  localparam logic [CW-1:0] LAST = CW'(K - 1);

  mont_state_e state_q;
  logic [CW-1:0] cnt_q;

  assign accept  = (state_q == ST_IDLE) && in_valid;
  assign step_en = (state_q == ST_RUN);
  assign fix_en  = (state_q == ST_FIX);
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (in_valid) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  fix_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cnt_q == LAST) |=> fix_en);
endmodule

// File: rtl/mont_step.sv
module mont_step #(
  parameter int K = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step_en,
  input  logic [K-1:0] a_in,
  input  logic [K-1:0] b_in,
  input  logic [K-1:0] n_in,
  output logic [K:0]   acc,
  output logic [K-1:0] mod_q
);
  localparam int SW = K + 2;

  logic [K-1:0] a_q, b_q;
  logic [K:0]   u_q;
  logic         a_bit, add_n;
  logic [SW-1:0] with_b, with_n;

  assign a_bit  = a_q[0];
  assign add_n  = u_q[0] ^ (a_bit & b_q[0]);
  assign with_b = SW'(u_q) + (a_bit ? SW'(b_q) : '0);
  assign with_n = with_b + (add_n ? SW'(mod_q) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      mod_q <= '0;
      u_q   <= '0;
    end else if (load) begin
      a_q   <= a_in;
      b_q   <= b_in;
      mod_q <= n_in;
      u_q   <= '0;
    end else if (step_en) begin
      a_q <= a_q >> 1;
      u_q <= with_n[K+1:1];
    end
  end

  assign acc = u_q;

  // R3
  even_before_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && mod_q[0]) |-> (with_n[0] == 1'b0));

  // R8
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && mod_q[0]) |-> (u_q < {mod_q, 1'b0}));
endmodule

// File: rtl/mont_fix.sv
module mont_fix #(
  parameter int K = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fix_en,
  input  logic [K:0]   acc,
  input  logic [K-1:0] mod_q,
  output logic [K-1:0] result,
  output logic         done
);
  logic [K:0]   diff;
  logic         need_sub;
  logic [K-1:0] res_q;
  logic         done_q;

  assign need_sub = (acc >= {1'b0, mod_q});
  assign diff     = acc - {1'b0, mod_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fix_en;
      if (fix_en) res_q <= need_sub ? diff[K-1:0] : acc[K-1:0];
    end
  end

  assign result = res_q;
  assign done   = done_q;

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mod_q[0]) |-> (res_q < mod_q));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fix_en) |-> $stable(res_q));
endmodule

// File: rtl/mont_mul_top.sv
module mont_mul_top #(
  parameter int K = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [K-1:0] op_a,
  input  logic [K-1:0] op_b,
  input  logic [K-1:0] modulus,
  output logic         busy,
  output logic         done,
  output logic [K-1:0] result
);
  logic accept, step_en, fix_en;
  logic [K:0]   acc;
  logic [K-1:0] mod_q;

  mont_ctrl #(.K(K)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .accept(accept), .step_en(step_en), .fix_en(fix_en), .busy(busy)
  );

  mont_step #(.K(K)) step_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .step_en(step_en),
    .a_in(op_a), .b_in(op_b), .n_in(modulus),
    .acc(acc), .mod_q(mod_q)
  );

  mont_fix #(.K(K)) fix_i (
    .clk(clk), .rst_n(rst_n), .fix_en(fix_en), .acc(acc), .mod_q(mod_q),
    .result(result), .done(done)
  );

  assign in_ready = !busy;

  // R6
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == !busy);

  // R6
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid) |=> $stable(mod_q));
endmodule

// File: tb/mont_mul_top_tb_top.sv
module mont_mul_top_tb_top;
  localparam int K = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [K-1:0] op_a = '0, op_b = '0, modulus = '0;
  logic in_ready, busy, done;
  logic [K-1:0] result;

  int checks = 0;
  int errors = 0;
  logic [31:0] lcg = 32'h1234_5677;

  always #10 clk = ~clk;

  mont_mul_top #(.K(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .modulus(modulus),
    .busy(busy), .done(done), .result(result)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_op(input int a, input int b, input int n, input bit junk);
    longint lhs, rhs;
    @(negedge clk);
    op_a = K'(a); op_b = K'(b); modulus = K'(n); in_valid = 1'b1;
    check(in_ready == 1'b1, "R6", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int j = 1; j <= K + 1; j++) begin
      if (junk && j < K) begin
        op_a = K'(n - 1); op_b = K'(n - 1); modulus = K'(n ^ 2); in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
      if (j <= K) begin
        if (done !== 1'b0 || busy !== 1'b1) check(1'b0, "R4", done, 0);
      end
    end
    in_valid = 1'b0;
    check(done === 1'b1 && busy === 1'b0, "R4", done, 1);
    check(result < K'(n), "R5", result, n - 1);
    lhs = (longint'(result) << K) % n;
    rhs = (longint'(a) * longint'(b)) % n;
    check(lhs == rhs, junk ? "R6" : "R2", lhs, rhs);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [K-1:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done === 1'b0, "R1", done, 0);
    check(busy === 1'b0, "R1", busy, 0);
    check(in_ready === 1'b1, "R1", in_ready, 1);
    check(result === '0, "R1", result, 0);
    rst_n = 1'b1;

    // R2 R5: sweep every odd modulus with edge and pseudo-random operands
    for (int n = 1; n < (1 << K); n += 2) begin
      run_op(0, 0, n, 1'b0);
      run_op(n - 1, n - 1, n, 1'b0);
      run_op(1, n - 1, n, 1'b0);
      run_op((n - 1) / 2, n - 1, n, 1'b0);
      for (int r = 0; r < 3; r++) begin
        int ra, rb;
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        ra = int'(lcg[31:16]) % n;
        rb = int'(lcg[15:0]) % n;
        run_op(ra, rb, n, 1'b0);
      end
    end

    // R6: request presented while busy must be ignored
    run_op(200, 77, 251, 1'b1);
    run_op(3, 5, 7, 1'b1);

    // R7: result held after done until the next product
    held = result;
    repeat (6) @(negedge clk);
    check(result === held, "R7", result, held);
    check(done === 1'b0, "R4", done, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule